// File: doc/BRIEF.md
# Encoded-Ratio Serial Clock Generator

This block derives the serial clock of an SPI master from the system clock and marks, with one-cycle strobes, the edges on which a separate shift engine should launch transmit data and sample receive data. The division ratio comes from a 16-bit encoded setting. A 3-bit low code selects a base power-of-two divider. A fixed divide-by-32 prestage is added when the upper byte carries a marker value. Together they cover eleven ratios from 1 to 1024.

The system clock is taken to run at twice the reference rate. A ratio R therefore gives R system cycles per serial-clock half period. Ratio 1 toggles the serial clock on every system cycle.

While the enable input is low, the serial clock rests at the level set by the polarity input. During that time the setting, polarity and phase inputs are captured every cycle. Once enable is high they are frozen, so a mid-run change cannot shorten a pulse. An acknowledge output repeats the enable one cycle later, so a controller can poll it.

Top module: `encSckGen`

## Requirements
- R1: With upper byte not 0x1F, low code 0,1,2,3,4 (bits 2:0) gives a half period of 2,4,8,16,32 system cycles.
- R2: Low code 7 gives a half period of 1 cycle, so sck toggles every system cycle while enabled.
- R3: Upper byte (bits 15:8) equal to 0x1F multiplies the half period by 32: 0x1F00 gives 64, 0x1F04 gives 1024, 0x1F07 gives 32.
- R4: Low codes 5 and 6 act as a base half period of 32. Bits 7:3 are ignored. Any upper byte other than 0x1F adds no prestage.
- R5: While clkEnable is low, sck equals the cpol input sampled at the previous clock edge.
- R6: The edge bit is cpol XOR NOT cpha, taken from the values captured while disabled. sampleStb pulses in the cycle sck first shows a new level when that level equals the edge bit. launchStb pulses on the other edges.
- R7: Changes to prescale, cpol or cpha while clkEnable is high do not alter sck or the strobes until clkEnable has been low for a cycle.
- R8: enableAck equals clkEnable delayed by one clock.
- R9: After clkEnable goes high, the first sck transition is visible after exactly H rising clock edges that sample it high, where H is the half period.
- R10: During reset, sck, sampleStb, launchStb and enableAck are all 0.
- R11: sampleStb and launchStb are never high together. Either pulses only in a cycle where sck has just changed, and neither pulses while disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkEnable | input | 1 | Runs the serial clock when high |
| prescale | input | 16 | Encoded ratio setting |
| cpol | input | 1 | Idle level of sck |
| cpha | input | 1 | Phase: 0 samples on the leading edge |
| sck | output | 1 | Serial clock |
| sampleStb | output | 1 | One-cycle pulse after a receive-sample edge |
| launchStb | output | 1 | One-cycle pulse after a transmit-change edge |
| enableAck | output | 1 | clkEnable delayed one cycle |

## Verification
A corrupted divide counter or a wrongly decoded setting shows at sck within one half period, as a transition one or more cycles early or late. A bad first-edge count shows on the very first transition after enable. A wrongly held or wrongly derived edge bit swaps sampleStb and launchStb on the next sck transition. An idle-level fault shows one cycle after enable drops. The bench compares every cycle against an independent model, so each of these faults is reported at its first visible cycle.

// File: rtl/encSckPkg.sv
package encSckPkg;
  // command word from the rate control to the edge datapath
  typedef struct packed {
    logic park;     // hold sck at idle level
    logic idleLvl;  // level used while parked
    logic toggle;   // invert sck this edge
    logic edgeSel;  // sck level that marks a sample edge
  } sckCmd_t;
endpackage

// File: rtl/sckRateCtrl.sv
module sckRateCtrl
  import encSckPkg::*;
#(
  parameter int SET_W    = 16,
  parameter int LOW_W    = 3,
  parameter int PRE_LOG2 = 5,
  parameter int MAX_LOG2 = 10,
  parameter logic [7:0] PRE_CODE = 8'h1F
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkEnable,
  input  logic [SET_W-1:0] setting,
  input  logic             cpol,
  input  logic             cpha,
  output sckCmd_t          cmd,
  output logic             enableAck
);
  localparam int CNT_W        = MAX_LOG2;
  localparam int EXP_W        = $clog2(MAX_LOG2 + 1);
  localparam int LOW_MAX_LOG2 = MAX_LOG2 - PRE_LOG2;

  logic [LOW_W-1:0] cfgLow;
  logic [7:0]       cfgHi;
  logic             cfgCpol, cfgCpha;
  logic [CNT_W-1:0] cnt, termVal;
  logic [EXP_W-1:0] lowExp, totExp;
  logic             atTerm;
  logic             unusedMid;

  assign unusedMid = ^setting[SET_W-9:LOW_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgLow    <= '0;
      cfgHi     <= '0;
      cfgCpol   <= 1'b0;
      cfgCpha   <= 1'b0;
      cnt       <= '0;
      enableAck <= 1'b0;
    end else begin
      enableAck <= clkEnable;
      if (!clkEnable) begin
        cfgLow  <= setting[LOW_W-1:0];
        cfgHi   <= setting[SET_W-1 -: 8];
        cfgCpol <= cpol;
        cfgCpha <= cpha;
        cnt     <= '0;
      end else if (atTerm) begin
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    if (cfgLow == '1)
      lowExp = '0;
    else if (int'(cfgLow) < LOW_MAX_LOG2)
      lowExp = EXP_W'(cfgLow) + EXP_W'(1);
    else
      lowExp = EXP_W'(LOW_MAX_LOG2);
    totExp  = lowExp + ((cfgHi == PRE_CODE) ? EXP_W'(PRE_LOG2) : EXP_W'(0));
    termVal = CNT_W'((32'd1 << totExp) - 32'd1);
    atTerm  = (cnt == termVal);
  end

  assign cmd.park    = !clkEnable;
  assign cmd.idleLvl = cpol;
  assign cmd.toggle  = clkEnable && atTerm;
  assign cmd.edgeSel = cfgCpol ^ ~cfgCpha;

  p_ack_high_r8: assert property (@(posedge clk) disable iff (!rstN)
    clkEnable |=> enableAck);
  p_ack_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    !clkEnable |=> !enableAck);
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    clkEnable |=> $stable({cfgLow, cfgHi, cfgCpol, cfgCpha}));
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= termVal);
endmodule

// File: rtl/sckEdgeGen.sv
module sckEdgeGen
  import encSckPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  sckCmd_t cmd,
  output logic    sck,
  output logic    sampleStb,
  output logic    launchStb
);
  logic nextSck;
  assign nextSck = ~sck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sck       <= 1'b0;
      sampleStb <= 1'b0;
      launchStb <= 1'b0;
    end else if (cmd.park) begin
      sck       <= cmd.idleLvl;
      sampleStb <= 1'b0;
      launchStb <= 1'b0;
    end else if (cmd.toggle) begin
      sck       <= nextSck;
      sampleStb <= (nextSck == cmd.edgeSel);
      launchStb <= (nextSck != cmd.edgeSel);
    end else begin
      sampleStb <= 1'b0;
      launchStb <= 1'b0;
    end
  end

  p_idle_level_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmd.park |=> (sck == $past(cmd.idleLvl)));
  p_excl_strobe_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sampleStb, launchStb}));
  p_strobe_on_edge_r11: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStb || launchStb) |-> (sck != $past(sck)));
  p_sample_dir_r6: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |-> (sck == $past(cmd.edgeSel)));
endmodule

// File: rtl/encSckGen.sv
module encSckGen
  import encSckPkg::*;
#(
  parameter int SET_W    = 16,
  parameter int LOW_W    = 3,
  parameter int PRE_LOG2 = 5,
  parameter int MAX_LOG2 = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkEnable,
  input  logic [SET_W-1:0] prescale,
  input  logic             cpol,
  input  logic             cpha,
  output logic             sck,
  output logic             sampleStb,
  output logic             launchStb,
  output logic             enableAck
);
  sckCmd_t cmd;

  sckRateCtrl #(
    .SET_W(SET_W), .LOW_W(LOW_W), .PRE_LOG2(PRE_LOG2),
    .MAX_LOG2(MAX_LOG2), .PRE_CODE(8'h1F)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .clkEnable(clkEnable), .setting(prescale),
    .cpol(cpol), .cpha(cpha), .cmd(cmd), .enableAck(enableAck)
  );

  sckEdgeGen uEdge (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .sck(sck), .sampleStb(sampleStb), .launchStb(launchStb)
  );
endmodule

// File: tb/encSckGen_test.sv
`timescale 1ns/1ps
module encSckGen_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic en = 1'b0;
  logic [15:0] prescale = '0;
  logic cpol = 1'b0, cpha = 1'b0;
  logic sck, sampleStb, launchStb, enableAck;

  int checkCnt = 0, failCnt = 0, cyc = 0;
  string curTag = "R1";
  bit modelOn = 1'b0;

  // reference model state
  int  mRatio = 2, mCnt = 0;
  logic mSck = 1'b0, mEdge = 1'b1, mAck = 1'b0, mS = 1'b0, mL = 1'b0;

  always #4 clk = ~clk;

  encSckGen uut (
    .clk(clk), .rstN(rstN), .clkEnable(en), .prescale(prescale),
    .cpol(cpol), .cpha(cpha), .sck(sck), .sampleStb(sampleStb),
    .launchStb(launchStb), .enableAck(enableAck)
  );

  function automatic int ratioOf(input logic [15:0] s);
    int base;
    case (s[2:0])
      3'd0: base = 2;
      3'd1: base = 4;
      3'd2: base = 8;
      3'd3: base = 16;
      3'd7: base = 1;
      default: base = 32;
    endcase
    if (s[15:8] == 8'h1F) base = base * 32;
    return base;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSck = 0; mAck = 0; mS = 0; mL = 0; mCnt = 0;
    end else begin
      mAck = en;
      mS = 0; mL = 0;
      if (!en) begin
        mSck = cpol; mCnt = 0;
        mRatio = ratioOf(prescale);
        mEdge = cpol ^ ~cpha;
      end else begin
        mCnt++;
        if (mCnt == mRatio) begin
          mCnt = 0;
          mSck = ~mSck;
          if (mSck == mEdge) mS = 1; else mL = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && modelOn) begin
      check(sck == mSck, curTag, sck, mSck);
      check(sampleStb == mS && launchStb == mL, "R6",
            {sampleStb, launchStb}, {mS, mL});
      check(enableAck == mAck, "R8", enableAck, mAck);
      check(!(sampleStb && launchStb), "R11", {sampleStb, launchStb}, 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      finishRun();
    end
  end

  task automatic runCase(input logic [15:0] s, input logic cp, input logic ch,
                         input int cycles, input bit scramble, input string tag);
    @(negedge clk);
    en = 0; prescale = s; cpol = cp; cpha = ch;
    repeat (2) @(negedge clk);
    curTag = tag;
    en = 1;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (scramble) begin
        prescale = 16'($urandom);
        cpol = 1'($urandom);
        cpha = 1'($urandom);
      end
    end
    en = 0; cpol = cp;
    repeat (3) @(negedge clk);
  endtask

  task automatic firstEdge(input logic [15:0] s, input logic cp);
    int k;
    @(negedge clk);
    en = 0; prescale = s; cpol = cp; cpha = 0;
    repeat (3) @(negedge clk);
    curTag = "R9";
    en = 1;
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (sck == cp && k < 3000);
    check(k == ratioOf(s), "R9", k, ratioOf(s));
    en = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R10 reset state
    check(sck == 0, "R10", sck, 0);
    check(sampleStb == 0 && launchStb == 0, "R10", {sampleStb, launchStb}, 0);
    check(enableAck == 0, "R10", enableAck, 0);
    rstN = 1;
    modelOn = 1;
    // R5 idle level while disabled
    cpol = 1; repeat (2) @(negedge clk);
    check(sck == 1, "R5", sck, 1);
    check(sampleStb == 0 && launchStb == 0, "R11", {sampleStb, launchStb}, 0);
    cpol = 0; repeat (2) @(negedge clk);
    check(sck == 0, "R5", sck, 0);

    runCase(16'h0007, 0, 0, 24, 0, "R2");
    runCase(16'h0007, 1, 1, 24, 0, "R2");
    for (int c = 0; c < 5; c++)
      runCase(16'(c), 1'(c), 1'(c >> 1), 8 * ratioOf(16'(c)) + 5, 0, "R1");
    runCase(16'h1F00, 0, 1, 300, 0, "R3");
    runCase(16'h1F07, 1, 0, 150, 0, "R3");
    runCase(16'h1F04, 0, 0, 4200, 0, "R3");
    runCase(16'h0005, 1, 1, 140, 0, "R4");
    runCase(16'h0006, 0, 1, 140, 0, "R4");
    runCase(16'h2301, 1, 0, 40, 0, "R4");
    runCase(16'h00F9, 0, 0, 40, 0, "R4");
    runCase(16'h0002, 0, 0, 200, 1, "R7");
    runCase(16'h0007, 1, 1, 60, 1, "R7");
    firstEdge(16'h0007, 0);
    firstEdge(16'h0003, 1);
    firstEdge(16'h1F00, 0);

    for (int r = 0; r < 25; r++) begin
      logic [15:0] s;
      s = 16'($urandom);
      if ($urandom % 3 != 0) s[15:8] = ($urandom % 2) ? 8'h1F : 8'h00;
      runCase(s, 1'($urandom), 1'($urandom), 3 * ratioOf(s) + 8,
              1'($urandom % 4 == 0), "R1");
    end
    finishRun();
  end
endmodule